// File: doc/BRIEF.md
# Companion-Chip Control and GPIO Register Block

This block is the register file of a handheld companion chip. It sits in a 4 KB address window and holds sixteen-bit registers for operating mode, card detection, card status, card power, card control, three interrupt words, and a general-purpose I/O group. A simple synchronous bus reaches it by byte offset. A write is taken on the clock edge where the write enable is high. A read is requested with the read enable, and its data appears on the registered read port one cycle later.

The I/O group drives sixteen output lines. A direction word selects which lines are outputs. A level word holds the requested values, and a spare readback word is plain storage. The value actually driven on a line is its level bit ANDed with its direction bit. This effective value is recomputed only after a bus write to the direction or level word. Every line whose effective value flips on such a write gets a one-cycle change strobe. Sixteen external update inputs can force individual level bits high or low, but they do not by themselves change the outputs. The interrupt words are storage only and generate nothing.

Top module: `cc_gpio_regs`

## Requirements
- R1: After reset, card status (offset 0x08) reads 0x0002. Every other register reads 0x0000, and `gpio_o` and `gpio_chg_o` are zero.
- R2: Writes to the plain registers keep only `wdata_i[15:0]`. The plain registers are mode 0x00, card detect 0x04, card control 0x10, interrupt request 0x14, interrupt mask 0x18, interrupt status 0x1C and readback 0x28. A read returns the stored value zero-extended on `rdata_o`, one cycle after `re_i`.
- R3: A write to card power (0x0C) stores `wdata_i[15:0]`. If bit 7 of that value is 1, bits 15 and 6 are also stored as 1.
- R4: Card status (0x08) is read-only. Writes to it leave it at 0x0002.
- R5: A write to the level word (0x24) stores the write data ANDed with the direction word (0x20) as it was before that edge.
- R6: After the edge of any write to 0x20 or 0x24, `gpio_o` equals level AND direction. `gpio_chg_o` is high for exactly that one cycle, and only on the bits that flipped.
- R7: `gpio_o` and `gpio_chg_o` do not change in any cycle without a write to 0x20 or 0x24. External level updates do not change them.
- R8: If `ext_upd_i[n]` is 1, level bit n takes `ext_val_i[n]`, whatever the direction. A bus write to 0x24 in the same cycle overrides all external updates.
- R9: A read of any offset not listed above, including offsets that are not multiples of four, returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset in the window |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data; only bits 15:0 are used |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, valid the cycle after `re_i` |
| ext_upd_i | input | 16 | Per-line enable for external level updates |
| ext_val_i | input | 16 | Per-line value for external level updates |
| gpio_o | output | 16 | Effective output levels |
| gpio_chg_o | output | 16 | Per-line change strobes |

## Verification
A wrong previous-output register shows at the ports on the first write to direction or level. The strobes then name the wrong lines, or fire when nothing flipped. Masking errors in the level word show on the next read of 0x24 and on `gpio_o` after the next write to the I/O group. Lost or extra power bits show on the next read of 0x0C. A decode fault that aliases an unmapped offset onto a register shows when the full register set is read back after the stray write. Random traffic mixed with external updates compares every output each cycle against a bench model, so a divergence is reported within one cycle of being visible.

// File: rtl/cc_regs_pkg.sv
package cc_regs_pkg;
  localparam int unsigned WIN_AW = 12;
  localparam int unsigned REG_W  = 16;

  localparam logic [WIN_AW-1:0] OFS_MODE = 12'h000;
  localparam logic [WIN_AW-1:0] OFS_CDET = 12'h004;
  localparam logic [WIN_AW-1:0] OFS_STAT = 12'h008;
  localparam logic [WIN_AW-1:0] OFS_PWR  = 12'h00C;
  localparam logic [WIN_AW-1:0] OFS_CCTL = 12'h010;
  localparam logic [WIN_AW-1:0] OFS_IREQ = 12'h014;
  localparam logic [WIN_AW-1:0] OFS_IMSK = 12'h018;
  localparam logic [WIN_AW-1:0] OFS_ISTA = 12'h01C;
  localparam logic [WIN_AW-1:0] OFS_GDIR = 12'h020;
  localparam logic [WIN_AW-1:0] OFS_GLVL = 12'h024;
  localparam logic [WIN_AW-1:0] OFS_GRBK = 12'h028;

  localparam logic [REG_W-1:0] STAT_RST    = 16'h0002;
  localparam int unsigned      PWR_TRIG    = 7;
  localparam logic [REG_W-1:0] PWR_FORCE   = 16'h8040;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_CDET, SEL_STAT, SEL_PWR, SEL_CCTL, SEL_IREQ,
    SEL_IMSK, SEL_ISTA, SEL_GDIR, SEL_GLVL, SEL_GRBK, SEL_NONE
  } reg_sel_e;

  localparam int unsigned N_PLAIN = 7;
  localparam reg_sel_e PLAIN_SEL [N_PLAIN] = '{
    SEL_MODE, SEL_CDET, SEL_CCTL, SEL_IREQ, SEL_IMSK, SEL_ISTA, SEL_GRBK
  };
endpackage

// File: rtl/cc_addr_dec.sv
module cc_addr_dec
  import cc_regs_pkg::*;
(
  input  logic [WIN_AW-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      OFS_MODE: sel_o = SEL_MODE;
      OFS_CDET: sel_o = SEL_CDET;
      OFS_STAT: sel_o = SEL_STAT;
      OFS_PWR:  sel_o = SEL_PWR;
      OFS_CCTL: sel_o = SEL_CCTL;
      OFS_IREQ: sel_o = SEL_IREQ;
      OFS_IMSK: sel_o = SEL_IMSK;
      OFS_ISTA: sel_o = SEL_ISTA;
      OFS_GDIR: sel_o = SEL_GDIR;
      OFS_GLVL: sel_o = SEL_GLVL;
      OFS_GRBK: sel_o = SEL_GRBK;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/cc_ctrl_regs.sv
module cc_ctrl_regs
  import cc_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] plain_o [N_PLAIN],
  output logic [REG_W-1:0] pwr_o,
  output logic [REG_W-1:0] stat_o
);
  logic [REG_W-1:0] pwr_q;

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    logic [REG_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          r_q <= '0;
      else if (we_i && sel_i == PLAIN_SEL[i]) r_q <= wdata_i;
    end
    assign plain_o[i] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= '0;
    else if (we_i && sel_i == SEL_PWR)
      pwr_q <= wdata_i | (wdata_i[PWR_TRIG] ? PWR_FORCE : '0);
  end

  assign pwr_o  = pwr_q;
  assign stat_o = STAT_RST;

  // R3
  pwr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && sel_i == SEL_PWR && wdata_i[PWR_TRIG])
      |-> ((pwr_q & PWR_FORCE) == PWR_FORCE));
endmodule

// File: rtl/cc_gpio_core.sv
module cc_gpio_core
  import cc_regs_pkg::*;
#(
  parameter int unsigned N_LINES = REG_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_dir_i,
  input  logic               wr_lvl_i,
  input  logic [N_LINES-1:0] wdata_i,
  input  logic [N_LINES-1:0] ext_upd_i,
  input  logic [N_LINES-1:0] ext_val_i,
  output logic [N_LINES-1:0] dir_o,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] gpio_o,
  output logic [N_LINES-1:0] chg_o
);
  logic [N_LINES-1:0] dir_q, lvl_q, dir_nxt, lvl_nxt, eff_nxt;
  logic [N_LINES-1:0] prev_q, chg_q;
  logic               touch;

  always_comb begin
    dir_nxt = wr_dir_i ? wdata_i : dir_q;
    // bus write to level overrides external updates
    lvl_nxt = wr_lvl_i ? (wdata_i & dir_q)
                       : ((lvl_q & ~ext_upd_i) | (ext_val_i & ext_upd_i));
    eff_nxt = lvl_nxt & dir_nxt;
  end

  assign touch = wr_dir_i | wr_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      dir_q <= dir_nxt;
      lvl_q <= lvl_nxt;
    end
  end

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[n] <= 1'b0;
        chg_q[n]  <= 1'b0;
      end else begin
        chg_q[n] <= touch && (prev_q[n] != eff_nxt[n]);
        if (touch) prev_q[n] <= eff_nxt[n];
      end
    end
  end

  assign dir_o  = dir_q;
  assign lvl_o  = lvl_q;
  assign gpio_o = prev_q;
  assign chg_o  = chg_q;

  // R6
  chg_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chg_q) |-> $past(touch));
  // R6
  chg_marks_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q ^ $past(prev_q)) == chg_q);
  // R5
  lvl_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_lvl_i) |-> ((lvl_q & ~$past(dir_q)) == '0));
endmodule

// File: rtl/cc_gpio_regs.sv
module cc_gpio_regs
  import cc_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [REG_W-1:0]  ext_upd_i,
  input  logic [REG_W-1:0]  ext_val_i,
  output logic [REG_W-1:0]  gpio_o,
  output logic [REG_W-1:0]  gpio_chg_o
);
  localparam int unsigned PAD_W = DATA_W - REG_W;

  reg_sel_e         sel;
  logic [REG_W-1:0] wd16;
  logic [REG_W-1:0] plain [N_PLAIN];
  logic [REG_W-1:0] pwr, stat, dir, lvl, rd_val;
  logic [DATA_W-1:0] rdata_q;

  assign wd16 = wdata_i[REG_W-1:0];

  cc_addr_dec u_dec (.addr_i(addr_i), .sel_o(sel));

  cc_ctrl_regs u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .sel_i(sel),
    .wdata_i(wd16), .plain_o(plain), .pwr_o(pwr), .stat_o(stat)
  );

  cc_gpio_core #(.N_LINES(REG_W)) u_gpio (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_dir_i(we_i && sel == SEL_GDIR),
    .wr_lvl_i(we_i && sel == SEL_GLVL),
    .wdata_i(wd16), .ext_upd_i(ext_upd_i), .ext_val_i(ext_val_i),
    .dir_o(dir), .lvl_o(lvl), .gpio_o(gpio_o), .chg_o(gpio_chg_o)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_PLAIN; i++)
      if (sel == PLAIN_SEL[i]) rd_val = plain[i];
    case (sel)
      SEL_STAT: rd_val = stat;
      SEL_PWR:  rd_val = pwr;
      SEL_GDIR: rd_val = dir;
      SEL_GLVL: rd_val = lvl;
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= {{PAD_W{1'b0}}, rd_val};
  end

  assign rdata_o = rdata_q;

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(re_i && sel == SEL_NONE) |-> (rdata_o == '0));
  // R2
  rdata_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(re_i) |-> (rdata_o[DATA_W-1:REG_W] == '0));
endmodule

// File: tb/cc_gpio_regs_tb_top.sv
module cc_gpio_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [15:0] ext_upd = '0, ext_val = '0;
  logic [31:0] rdata;
  logic [15:0] gpio, gchg;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [15:0] m_mode, m_cdet, m_pwr, m_cctl, m_ireq, m_imsk, m_ista;
  logic [15:0] m_dir, m_lvl, m_grbk, m_prev, m_chg;
  logic [31:0] m_rd;

  always #10 clk = ~clk;

  cc_gpio_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .ext_upd_i(ext_upd), .ext_val_i(ext_val),
    .gpio_o(gpio), .gpio_chg_o(gchg)
  );

  function automatic logic [15:0] model_read(logic [11:0] a);
    case (a)
      12'h000: return m_mode;
      12'h004: return m_cdet;
      12'h008: return 16'h0002;
      12'h00C: return m_pwr;
      12'h010: return m_cctl;
      12'h014: return m_ireq;
      12'h018: return m_imsk;
      12'h01C: return m_ista;
      12'h020: return m_dir;
      12'h024: return m_lvl;
      12'h028: return m_grbk;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] pwr_value(logic [15:0] w);
    return w[7] ? (w | 16'h8040) : w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_cdet = 0; m_pwr = 0; m_cctl = 0; m_ireq = 0; m_imsk = 0;
    m_ista = 0; m_dir = 0; m_lvl = 0; m_grbk = 0; m_prev = 0; m_chg = 0;
    m_rd = 0;
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic step(logic w, logic [11:0] a, logic [31:0] d, logic r,
                      logic [15:0] eu, logic [15:0] ev, string tag);
    logic [15:0] d16, dir_n, lvl_n, eff;
    d16 = d[15:0];
    we = w; addr = a; wdata = d; re = r; ext_upd = eu; ext_val = ev;
    if (r) m_rd = {16'h0, model_read(a)};
    dir_n = m_dir;
    lvl_n = (m_lvl & ~eu) | (ev & eu);
    if (w) begin
      case (a)
        12'h000: m_mode = d16;
        12'h004: m_cdet = d16;
        12'h00C: m_pwr  = pwr_value(d16);
        12'h010: m_cctl = d16;
        12'h014: m_ireq = d16;
        12'h018: m_imsk = d16;
        12'h01C: m_ista = d16;
        12'h020: dir_n  = d16;
        12'h024: lvl_n  = d16 & m_dir;
        12'h028: m_grbk = d16;
        default: ;
      endcase
    end
    if (w && (a == 12'h020 || a == 12'h024)) begin
      eff = lvl_n & dir_n;
      m_chg = m_prev ^ eff;
      m_prev = eff;
    end else begin
      m_chg = '0;
    end
    m_dir = dir_n; m_lvl = lvl_n;
    @(negedge clk);
    we = 0; re = 0; ext_upd = '0;
    chk({tag, " R6 gpio"}, {16'h0, gpio}, {16'h0, m_prev});
    chk({tag, " R7 strobe"}, {16'h0, gchg}, {16'h0, m_chg});
    if (r) chk({tag, " read"}, rdata, m_rd);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    step(1, a, d, 0, '0, '0, tag);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(0, a, '0, 1, '0, '0, tag);
  endtask

  localparam logic [11:0] ADDRS [14] = '{
    12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018,
    12'h01C, 12'h020, 12'h024, 12'h028, 12'h02C, 12'h002, 12'hFFC
  };

  initial begin
    model_reset();
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 gpio", {16'h0, gpio}, 32'h0);
    chk("R1 chg", {16'h0, gchg}, 32'h0);
    for (int i = 0; i < 11; i++) rd(ADDRS[i], "R1");

    // R2 truncation
    wr(12'h000, 32'hDEAD_5678, "R2");
    rd(12'h000, "R2 mode");
    wr(12'h01C, 32'hFFFF_A5A5, "R2");
    rd(12'h01C, "R2 ista");
    // R3 power forcing
    wr(12'h00C, 32'h0000_0080, "R3");
    rd(12'h00C, "R3 force");
    chk("R3 value", rdata, 32'h0000_80C0);
    wr(12'h00C, 32'h0000_0101, "R3");
    rd(12'h00C, "R3 noforce");
    // R4 status read only
    wr(12'h008, 32'h0000_FFFF, "R4");
    rd(12'h008, "R4");
    chk("R4 value", rdata, 32'h0000_0002);
    // R5 masking, R6 strobes
    wr(12'h024, 32'h0000_FFFF, "R5 no dir");
    rd(12'h024, "R5 lvl zero");
    wr(12'h020, 32'h0000_00FF, "R6 dir");
    wr(12'h024, 32'h0000_FFFF, "R5 masked");
    chk("R6 gpio", {16'h0, gpio}, 32'h00FF);
    chk("R6 strobe", {16'h0, gchg}, 32'h00FF);
    rd(12'h024, "R5 lvl");
    wr(12'h024, 32'h0000_00FF, "R6 same");
    chk("R6 no flip", {16'h0, gchg}, 32'h0);
    // R7/R8 external update on an input and an output line
    step(0, 12'h000, '0, 0, 16'h0101, 16'h0100, "R8 ext");
    chk("R7 gpio held", {16'h0, gpio}, 32'h00FF);
    rd(12'h024, "R8 lvl");
    chk("R8 value", rdata, 32'h01FE);
    wr(12'h020, 32'h0000_01FF, "R6 dir widen");
    chk("R6 toggles", {16'h0, gchg}, 32'h0101);
    // R8 bus write wins over external update
    step(1, 12'h024, 32'h0000_000F, 0, 16'hFFFF, 16'hFFFF, "R8 collide");
    rd(12'h024, "R8 bus wins");
    chk("R8 win value", rdata, 32'h000F);
    // R9 unmapped
    wr(12'h02C, 32'hFFFF_FFFF, "R9");
    wr(12'h002, 32'hFFFF_FFFF, "R9");
    wr(12'hFFC, 32'hFFFF_FFFF, "R9");
    for (int i = 0; i < 14; i++) rd(ADDRS[i], "R9 sweep");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] a;
      logic [15:0] eu;
      a  = ADDRS[$urandom % 14];
      eu = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      step(1'($urandom), a, $urandom, 1'($urandom), eu, 16'($urandom), "RND");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule